// File: doc/BRIEF.md
# Postfix Expression Evaluator

This block evaluates an arithmetic expression that arrives as a postfix (reverse Polish) byte stream. Each byte is an operand or an operator code. Operand bytes push a value onto an internal stack. Operator bytes take the top two values and replace them with the result. An end byte closes the expression, publishes the value left on the stack, and pulses `done` for one cycle.

Bytes enter through a valid/ready handshake. Addition, subtraction and multiplication finish in the cycle the operator is accepted. Integer power is computed by repeated multiplication, one step per cycle, and `in_ready` stays low while it runs. The result has a fixed width of `WIDTH` bits. Three status flags are published with each result:
- overflow,
- negative-difference underflow,
- malformed-stream format error.

The controller has three states:
- `S_ACCEPT`: takes bytes.
- `S_POWER`: runs the multiply loop.
- `S_DONE`: presents the result and empties the stack.

The transitions are:
- `S_ACCEPT`→`S_POWER` on an accepted power code with two stack entries.
- `S_POWER`→`S_ACCEPT` when the exponent count reaches zero.
- `S_ACCEPT`→`S_DONE` on an accepted end byte.
- `S_DONE`→`S_ACCEPT` always, after one cycle.

Top module: `postfix_eval`

## Requirements
- R1: A byte 0x00–0x7F, accepted while `in_ready` is high, pushes its 7-bit value (zero-extended) onto the stack.
- R2: Codes 0x80 (add), 0x81 (subtract) and 0x82 (multiply) pop the right operand (top), then the left, and push left op right. This completes in the accepting cycle.
- R3: An add, multiply or power result that exceeds WIDTH bits keeps its low WIDTH bits and sets `ovf_flag` for that expression.
- R4: A subtraction whose right operand is larger than its left pushes 0 and sets `udf_flag` for that expression.
- R5: Code 0x83 raises left to the power right by repeated multiplication. `in_ready` is low from the cycle after the code is accepted until the loop ends, and an exponent of 0 yields 1.
- R6: Code 0xFF causes the following behaviour:
  - `done` is high for exactly the one cycle after the byte is accepted.
  - `result` then shows the stack top, or 0 if the stack is empty.
- R7: `fmt_err` is set in any of these cases:
  - the stack does not hold exactly one value at the end byte;
  - an operator finds fewer than two entries (the operator is skipped);
  - a push meets a full stack of DEPTH entries (the byte is dropped);
  - an undefined code 0x84–0xFE is received.
- R8: The result and flags hold their values until the next `done`. In the `done` cycle the stack and the per-expression flags are cleared, so the next expression starts fresh, and `in_ready` returns the cycle after `done`.
- R9: After reset the outputs are as follows: `in_ready`=1, `done`=0, `result`=0, and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte valid |
| in_byte | input | 8 | Operand or operator code |
| in_ready | output | 1 | Byte is taken when high together with in_valid |
| done | output | 1 | One-cycle pulse when a result is published |
| result | output | WIDTH | Value of the last finished expression |
| ovf_flag | output | 1 | Last expression overflowed WIDTH bits |
| udf_flag | output | 1 | Last expression had a negative difference |
| fmt_err | output | 1 | Last expression was malformed |

## Verification
The bound checker watches the following on every cycle:
- the one-cycle width of `done`;
- the stall of `in_ready` while the power loop has exponent steps left;
- the bound on the stack depth;
- the empty stack after each publish;
- the published values not moving except in the `done` cycle.

The arithmetic itself can only be shown by the bench's expressions:
- operand order for subtraction and power;
- truncation on overflow;
- zero exponents;
- the clearing of sticky flags between expressions;
- each cause of a format error.

// File: rtl/postfix_pkg.sv
package postfix_pkg;
    typedef enum logic [1:0] {
        S_ACCEPT,
        S_POWER,
        S_DONE
    } state_t;

    localparam logic [7:0] CODE_ADD = 8'h80;
    localparam logic [7:0] CODE_SUB = 8'h81;
    localparam logic [7:0] CODE_MUL = 8'h82;
    localparam logic [7:0] CODE_POW = 8'h83;
    localparam logic [7:0] CODE_END = 8'hFF;
endpackage

// File: rtl/pf_stack.sv
module pf_stack #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 8,
    localparam int CW = $clog2(DEPTH + 2),
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             combine,
    input  logic             clear,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] top,
    output logic [WIDTH-1:0] below,
    output logic [CW-1:0]    count,
    output logic             full
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [CW-1:0]    cnt_m1;
    logic [CW-1:0]    cnt_m2;

    assign cnt_m1 = count - CW'(1);
    assign cnt_m2 = count - CW'(2);
    assign full   = (count == CW'(DEPTH));
    assign top    = (count >= CW'(1)) ? mem[IW'(cnt_m1)] : '0;
    assign below  = (count >= CW'(2)) ? mem[IW'(cnt_m2)] : '0;

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem[i] <= '0;
            end else if (push && !full && count == CW'(i)) begin
                mem[i] <= wdata;
            end else if (combine && count == CW'(i + 2)) begin
                mem[i] <= wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (push && !full) begin
            count <= count + CW'(1);
        end else if (combine && count >= CW'(2)) begin
            count <= cnt_m1;
        end
    end
endmodule

// File: rtl/pf_alu.sv
module pf_alu #(
    parameter int WIDTH = 16
) (
    input  logic [1:0]       op,
    input  logic [WIDTH-1:0] lhs,
    input  logic [WIDTH-1:0] rhs,
    output logic [WIDTH-1:0] y,
    output logic             ovf,
    output logic             udf
);
    logic [WIDTH:0]     sum;
    logic [2*WIDTH-1:0] prod;

    assign sum  = {1'b0, lhs} + {1'b0, rhs};
    assign prod = {{WIDTH{1'b0}}, lhs} * {{WIDTH{1'b0}}, rhs};

    always_comb begin
        y   = '0;
        ovf = 1'b0;
        udf = 1'b0;
        case (op)
            2'd0: begin
                y   = sum[WIDTH-1:0];
                ovf = sum[WIDTH];
            end
            2'd1: begin
                if (rhs > lhs) begin
                    udf = 1'b1;
                end else begin
                    y = lhs - rhs;
                end
            end
            2'd2: begin
                y   = prod[WIDTH-1:0];
                ovf = |prod[2*WIDTH-1:WIDTH];
            end
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/pf_power.sv
module pf_power #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [WIDTH-1:0] base_in,
    input  logic [WIDTH-1:0] expo_in,
    output logic             fin,
    output logic [WIDTH-1:0] acc,
    output logic             ovf
);
    logic [WIDTH-1:0]   base_q;
    logic [WIDTH-1:0]   expo_q;
    logic [2*WIDTH-1:0] prod;

    assign prod = {{WIDTH{1'b0}}, acc} * {{WIDTH{1'b0}}, base_q};
    assign fin  = (expo_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            expo_q <= '0;
            acc    <= '0;
            ovf    <= 1'b0;
        end else if (start) begin
            base_q <= base_in;
            expo_q <= expo_in;
            acc    <= WIDTH'(1);
            ovf    <= 1'b0;
        end else if (!fin) begin
            acc    <= prod[WIDTH-1:0];
            expo_q <= expo_q - WIDTH'(1);
            ovf    <= ovf | (|prod[2*WIDTH-1:WIDTH]);
        end
    end
endmodule

// File: rtl/postfix_eval.sv
module postfix_eval
    import postfix_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_byte,
    output logic             in_ready,
    output logic             done,
    output logic [WIDTH-1:0] result,
    output logic             ovf_flag,
    output logic             udf_flag,
    output logic             fmt_err
);
    localparam int CW = $clog2(DEPTH + 2);

    state_t state, state_nx;

    logic             accept, is_operand, is_arith, is_pow, is_end, is_bad;
    logic             st_push, st_comb, st_clear, st_full, has_two;
    logic [WIDTH-1:0] st_wdata, st_top, st_below;
    logic [CW-1:0]    st_cnt;
    logic [WIDTH-1:0] alu_y;
    logic             alu_ovf, alu_udf;
    logic             pw_start, pw_fin, pw_ovf;
    logic [WIDTH-1:0] pw_acc;
    logic             work_ovf, work_udf, work_fmt;

    assign accept     = in_valid && in_ready;
    assign is_operand = !in_byte[7];
    assign is_arith   = (in_byte == CODE_ADD) || (in_byte == CODE_SUB) || (in_byte == CODE_MUL);
    assign is_pow     = (in_byte == CODE_POW);
    assign is_end     = (in_byte == CODE_END);
    assign is_bad     = !is_operand && !is_arith && !is_pow && !is_end;
    assign has_two    = (st_cnt >= CW'(2));
    assign pw_start   = (state == S_ACCEPT) && accept && is_pow && has_two;

    pf_stack #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_stack (
        .clk(clk), .rst_n(rst_n), .push(st_push), .combine(st_comb),
        .clear(st_clear), .wdata(st_wdata), .top(st_top), .below(st_below),
        .count(st_cnt), .full(st_full)
    );

    pf_alu #(.WIDTH(WIDTH)) u_alu (
        .op(in_byte[1:0]), .lhs(st_below), .rhs(st_top),
        .y(alu_y), .ovf(alu_ovf), .udf(alu_udf)
    );

    pf_power #(.WIDTH(WIDTH)) u_power (
        .clk(clk), .rst_n(rst_n), .start(pw_start), .base_in(st_below),
        .expo_in(st_top), .fin(pw_fin), .acc(pw_acc), .ovf(pw_ovf)
    );

    // next state and stack control
    always_comb begin
        state_nx = state;
        st_push  = 1'b0;
        st_comb  = 1'b0;
        st_clear = 1'b0;
        st_wdata = alu_y;
        unique case (state)
            S_ACCEPT: begin
                if (accept) begin
                    if (is_operand) begin
                        st_push  = 1'b1;
                        st_wdata = {{(WIDTH-7){1'b0}}, in_byte[6:0]};
                    end else if (is_arith && has_two) begin
                        st_comb = 1'b1;
                    end else if (is_pow && has_two) begin
                        state_nx = S_POWER;
                    end else if (is_end) begin
                        state_nx = S_DONE;
                    end
                end
            end
            S_POWER: begin
                if (pw_fin) begin
                    st_comb  = 1'b1;
                    st_wdata = pw_acc;
                    state_nx = S_ACCEPT;
                end
            end
            S_DONE: begin
                st_clear = 1'b1;
                state_nx = S_ACCEPT;
            end
            default: state_nx = S_ACCEPT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_ACCEPT;
        else        state <= state_nx;
    end

    // sticky per-expression flags and published outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            work_ovf <= 1'b0;
            work_udf <= 1'b0;
            work_fmt <= 1'b0;
            result   <= '0;
            ovf_flag <= 1'b0;
            udf_flag <= 1'b0;
            fmt_err  <= 1'b0;
        end else begin
            unique case (state)
                S_ACCEPT: begin
                    if (accept) begin
                        if (is_operand && st_full) work_fmt <= 1'b1;
                        if ((is_arith || is_pow) && !has_two) work_fmt <= 1'b1;
                        if (is_bad) work_fmt <= 1'b1;
                        if (is_arith && has_two) begin
                            work_ovf <= work_ovf | alu_ovf;
                            work_udf <= work_udf | alu_udf;
                        end
                        if (is_end) begin
                            result   <= (st_cnt != '0) ? st_top : '0;
                            ovf_flag <= work_ovf;
                            udf_flag <= work_udf;
                            fmt_err  <= work_fmt | (st_cnt != CW'(1));
                        end
                    end
                end
                S_POWER: begin
                    if (pw_fin) work_ovf <= work_ovf | pw_ovf;
                end
                S_DONE: begin
                    work_ovf <= 1'b0;
                    work_udf <= 1'b0;
                    work_fmt <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    assign in_ready = (state == S_ACCEPT);
    assign done     = (state == S_DONE);
endmodule

// File: rtl/pf_eval_chk.sv
module pf_eval_chk #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 8,
    localparam int CW = $clog2(DEPTH + 2)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_ready,
    input logic             done,
    input logic [WIDTH-1:0] result,
    input logic             ovf_flag,
    input logic             udf_flag,
    input logic             fmt_err,
    input logic [CW-1:0]    st_cnt,
    input logic             pw_fin
);
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_busy_in_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !in_ready);

    p_power_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !pw_fin |-> !in_ready);

    p_ready_back_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> in_ready);

    p_stack_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (st_cnt == '0));

    p_result_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({result, ovf_flag, udf_flag, fmt_err}) |-> done);

    p_stack_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_cnt <= CW'(DEPTH));
endmodule

bind postfix_eval pf_eval_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .done(done),
    .result(result), .ovf_flag(ovf_flag), .udf_flag(udf_flag),
    .fmt_err(fmt_err), .st_cnt(st_cnt), .pw_fin(pw_fin)
);

// File: tb/postfix_eval_tb.sv
module postfix_eval_tb;
    localparam int CLK_P = 10;
    localparam int W     = 16;
    localparam int NV    = 14;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [7:0]   in_byte = 8'h00;
    logic         in_ready, done, ovf_flag, udf_flag, fmt_err;
    logic [W-1:0] result;
    int           total = 0;
    int           bad = 0;

    // byte lists, left-aligned, padded with the end code
    localparam logic [95:0] VB [NV] = '{
        96'h030480FF_FFFFFFFF_FFFFFFFF,  // 3+4
        96'h090581FF_FFFFFFFF_FFFFFFFF,  // 9-5
        96'h070682FF_FFFFFFFF_FFFFFFFF,  // 7*6
        96'h020A83FF_FFFFFFFF_FFFFFFFF,  // 2^10
        96'h050083FF_FFFFFFFF_FFFFFFFF,  // 5^0
        96'h02030482_80FFFFFF_FFFFFFFF,  // 2+3*4
        96'h030581FF_FFFFFFFF_FFFFFFFF,  // 3-5 underflow
        96'h6464820A_82FFFFFF_FFFFFFFF,  // 100*100*10 overflow
        96'h021183FF_FFFFFFFF_FFFFFFFF,  // 2^17 overflow
        96'h0304FFFF_FFFFFFFF_FFFFFFFF,  // two left on stack
        96'h80FFFFFF_FFFFFFFF_FFFFFFFF,  // operator on empty stack
        96'h0A020383_81FFFFFF_FFFFFFFF,  // 10-2^3
        96'h0590FFFF_FFFFFFFF_FFFFFFFF,  // undefined code
        96'h2AFFFFFF_FFFFFFFF_FFFFFFFF   // lone operand
    };
    localparam logic [W-1:0] VR [NV] = '{
        16'd7, 16'd4, 16'd42, 16'd1024, 16'd1, 16'd14, 16'd0,
        16'd34464, 16'd0, 16'd4, 16'd0, 16'd2, 16'd5, 16'd42
    };
    // {ovf, udf, fmt}
    localparam logic [2:0] VF [NV] = '{
        3'b000, 3'b000, 3'b000, 3'b000, 3'b000, 3'b000, 3'b010,
        3'b100, 3'b100, 3'b001, 3'b001, 3'b000, 3'b001, 3'b000
    };

    postfix_eval #(.WIDTH(W), .DEPTH(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .in_ready(in_ready), .done(done), .result(result),
        .ovf_flag(ovf_flag), .udf_flag(udf_flag), .fmt_err(fmt_err)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // sends bytes up to the end code; returns in the done cycle
    task automatic run_vec(input logic [95:0] bytes, input logic [W-1:0] exp_r,
                           input logic [2:0] exp_f, input string tag);
        for (int i = 0; i < 12; i++) begin
            send(bytes[95-8*i -: 8]);
            if (bytes[95-8*i -: 8] == 8'hFF) break;
        end
        chk({tag, " R6 done"}, 32'(done), 32'd1);
        chk({tag, " result"}, 32'(result), 32'(exp_r));
        chk({tag, " R3 ovf"}, 32'(ovf_flag), 32'(exp_f[2]));
        chk({tag, " R4 udf"}, 32'(udf_flag), 32'(exp_f[1]));
        chk({tag, " R7 fmt"}, 32'(fmt_err), 32'(exp_f[0]));
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9 ready", 32'(in_ready), 32'd1);
        chk("R9 done", 32'(done), 32'd0);
        chk("R9 result", 32'(result), 32'd0);
        chk("R9 flags", 32'({ovf_flag, udf_flag, fmt_err}), 32'd0);
        rst_n = 1'b1;

        // table: R1 R2 R3 R4 R5 R6 R7, with flags clearing between rows (R8)
        for (int v = 0; v < NV; v++) begin
            run_vec(VB[v], VR[v], VF[v], $sformatf("vec%0d", v));
        end

        // R1 operand value pushed unchanged
        run_vec(96'h7FFFFFFF_FFFFFFFF_FFFFFFFF, 16'd127, 3'b000, "R1 max operand");
        // R2 operand order for subtraction
        run_vec(96'h140681FF_FFFFFFFF_FFFFFFFF, 16'd14, 3'b000, "R2 20-6");

        // R5 stall during power, then R6/R8 pulse timing and hold
        send(8'h03);
        send(8'h04);
        send(8'h83);
        chk("R5 ready low in power", 32'(in_ready), 32'd0);
        send(8'hFF);
        chk("R5 3^4", 32'(result), 32'd81);
        chk("R6 done pulse", 32'(done), 32'd1);
        @(negedge clk);
        chk("R6 done one cycle", 32'(done), 32'd0);
        chk("R8 ready back", 32'(in_ready), 32'd1);
        chk("R8 result held", 32'(result), 32'd81);

        // R7 push into full stack is dropped: 1..9 then seven adds -> 36
        for (int k = 1; k <= 9; k++) send(8'(k));
        for (int k = 0; k < 7; k++) send(8'h80);
        send(8'hFF);
        chk("R7 full stack result", 32'(result), 32'd36);
        chk("R7 full stack fmt", 32'(fmt_err), 32'd1);

        // R8 flags cleared for the next expression
        run_vec(96'h0101_80FF_FFFFFFFF_FFFFFFFF, 16'd2, 3'b000, "R8 fresh");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule